// File: doc/BRIEF.md
# Hashed Inverted Page Table Search

This block turns a process-tagged virtual address into a physical address. It does this by searching a table that has one entry for each physical frame. Each entry records the process that owns the frame, the virtual page number mapped into it, and a valid flag. The entry's position in the table is the frame number, so a successful search gives the frame directly. No separate frame field is stored.

A request carries a process ID and a 32-bit virtual address. The upper 19 bits of the address are the page number and the lower 13 bits are the offset. The search starts at a hashed table index and reads one entry per cycle through a synchronous table port, moving forward one index at a time. It stops at the first matching entry or after a probe budget supplied with the request. A one-cycle done pulse then reports either the physical address or a not-found result, together with the number of entries examined.

Filling the table and servicing a not-found result belong to the surrounding logic.

Top module: `ipt_search`

## Requirements
- R1: The first table read of a search uses index `(vpn[9:0] XOR {1'b0, vpn[18:10]} XOR {2'b00, pid}) mod 1024`. Here vpn is `req_vaddr[31:13]` and pid is the 8-bit `req_pid`.
- R2: The table is read once per cycle at consecutive ascending indices. The index after 1023 is 0.
- R3: An entry matches only when its valid bit is 1 and both its process ID and its page number equal the request's. An entry with a clear valid bit, or one that differs in either field, does not end the search.
- R4: When the k-th examined entry, at index i, matches: `hit` is 1, `paddr` is `{i[9:0], req_vaddr[12:0]}`, and `probes` is k.
- R5: When `probe_limit` entries have been examined without a match: `hit` is 0 and `probes` equals `probe_limit`. A `probe_limit` of 0 makes no table reads and reports not-found with `probes` of 0.
- R6: `done` is high for exactly one cycle. Take the clock edge that samples the request as edge 0. `done` rises after edge k+1 for a match on the k-th entry, after edge L+1 for a miss with limit L, and after edge 1 for a limit of 0.
- R7: `busy` is high from the edge that samples the request until the edge that raises `done`. `req_valid` is ignored while `busy` is high. `hit`, `paddr` and `probes` hold their values until the next `done`.
- R8: After reset, `busy`, `done`, `hit`, `tbl_rd_en`, `paddr` and `probes` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a search (sampled only while idle) |
| req_pid | input | 8 | Process ID of the request |
| req_vaddr | input | 32 | Virtual address: page number [31:13], offset [12:0] |
| probe_limit | input | 11 | Maximum number of entries to examine |
| busy | output | 1 | A search is in progress |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_idx | output | 10 | Table index to read |
| tbl_ent_valid | input | 1 | Valid bit of the entry read on the previous cycle |
| tbl_ent_pid | input | 8 | Owner process ID of that entry |
| tbl_ent_vpn | input | 19 | Page number of that entry |
| done | output | 1 | One-cycle end-of-search pulse |
| hit | output | 1 | The last search found a match |
| paddr | output | 23 | Physical address: frame [22:13], offset [12:0] |
| probes | output | 11 | Entries examined by the last search |

## Verification
Edge 0 is the edge that samples the request. The read for the j-th probe is driven between edge j-1 and edge j. Its entry returns one cycle later, and the compare result appears as `done` one edge after that. So a match on probe k is due in the window after edge k+1, and a miss with limit L is due after edge L+1.

The bench works out the hashed start index, the matching probe and the done window from its own table model before each search. It then samples every output at the falling edge of each cycle from edge 0 through one cycle past `done`. In every one of those windows it compares `busy`, `done`, the read strobe and the read index against the window it predicted. The result outputs are checked in the done window and again one cycle later, to confirm the done pulse lasts one cycle and the results hold.

// File: rtl/ipt_search_pkg.sv
package ipt_search_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ipt_state_e;
endpackage

// File: rtl/ipt_hash.sv
// Folds page number and process ID into a starting table index.
module ipt_hash #(
  parameter int PID_W   = 8,
  parameter int VPN_W   = 19,
  parameter int FRAME_W = 10
) (
  input  logic [PID_W-1:0]   pid,
  input  logic [VPN_W-1:0]   vpn,
  output logic [FRAME_W-1:0] start_idx
);
  localparam int VCH = (VPN_W + FRAME_W - 1) / FRAME_W;
  localparam int PCH = (PID_W + FRAME_W - 1) / FRAME_W;

  function automatic logic [FRAME_W-1:0] fold_key(
    input logic [PID_W-1:0] p,
    input logic [VPN_W-1:0] v
  );
    logic [VCH*FRAME_W-1:0] vpad;
    logic [PCH*FRAME_W-1:0] ppad;
    logic [FRAME_W-1:0]     acc;
    vpad = '0;
    ppad = '0;
    vpad[VPN_W-1:0] = v;
    ppad[PID_W-1:0] = p;
    acc = '0;
    for (int i = 0; i < VCH; i++) acc ^= vpad[i*FRAME_W +: FRAME_W];
    for (int i = 0; i < PCH; i++) acc ^= ppad[i*FRAME_W +: FRAME_W];
    return acc;
  endfunction

  assign start_idx = fold_key(pid, vpn);
endmodule

// File: rtl/ipt_entry_match.sv
// Tag compare of a returned table entry against the search key.
module ipt_entry_match #(
  parameter int PID_W = 8,
  parameter int VPN_W = 19
) (
  input  logic             chk_en,
  input  logic             ent_valid,
  input  logic [PID_W-1:0] ent_pid,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic [PID_W-1:0] key_pid,
  input  logic [VPN_W-1:0] key_vpn,
  output logic             match
);
  logic pid_eq;
  logic vpn_eq;
  assign pid_eq = (ent_pid == key_pid);
  assign vpn_eq = (ent_vpn == key_vpn);
  assign match  = chk_en && ent_valid && pid_eq && vpn_eq;
endmodule

// File: rtl/ipt_search.sv
module ipt_search
  import ipt_search_pkg::*;
#(
  parameter int PID_W   = 8,
  parameter int VPN_W   = 19,
  parameter int OFF_W   = 13,
  parameter int FRAME_W = 10,
  parameter int LIMIT_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [PID_W-1:0]         req_pid,
  input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
  input  logic [LIMIT_W-1:0]       probe_limit,
  output logic                     busy,
  output logic                     tbl_rd_en,
  output logic [FRAME_W-1:0]       tbl_rd_idx,
  input  logic                     tbl_ent_valid,
  input  logic [PID_W-1:0]         tbl_ent_pid,
  input  logic [VPN_W-1:0]         tbl_ent_vpn,
  output logic                     done,
  output logic                     hit,
  output logic [FRAME_W+OFF_W-1:0] paddr,
  output logic [LIMIT_W-1:0]       probes
);
  localparam int VADDR_W = VPN_W + OFF_W;
  localparam int PADDR_W = FRAME_W + OFF_W;

  ipt_state_e          state_q;
  logic [PID_W-1:0]    pid_q;
  logic [VPN_W-1:0]    vpn_q;
  logic [OFF_W-1:0]    off_q;
  logic [LIMIT_W-1:0]  lim_q;
  logic [FRAME_W-1:0]  idx_q;
  logic [FRAME_W-1:0]  pend_idx_q;
  logic                pend_q;
  logic [LIMIT_W-1:0]  issued_q;
  logic [LIMIT_W-1:0]  checked_q;
  logic                done_q;
  logic                hit_q;
  logic [PADDR_W-1:0]  paddr_q;
  logic [LIMIT_W-1:0]  probes_q;

  // Named internal events
  logic [FRAME_W-1:0]  start_idx;
  logic                accept;
  logic                issue;
  logic                match_now;
  logic [LIMIT_W-1:0]  chk_next;
  logic                hit_ev;
  logic                miss_ev;
  logic                finish;

  ipt_hash #(
    .PID_W(PID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W)
  ) u_hash (
    .pid       (req_pid),
    .vpn       (req_vaddr[VADDR_W-1:OFF_W]),
    .start_idx (start_idx)
  );

  ipt_entry_match #(
    .PID_W(PID_W), .VPN_W(VPN_W)
  ) u_match (
    .chk_en    (pend_q),
    .ent_valid (tbl_ent_valid),
    .ent_pid   (tbl_ent_pid),
    .ent_vpn   (tbl_ent_vpn),
    .key_pid   (pid_q),
    .key_vpn   (vpn_q),
    .match     (match_now)
  );

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign issue    = (state_q == ST_RUN) && (issued_q < lim_q);
  assign chk_next = checked_q + LIMIT_W'(pend_q);
  assign hit_ev   = (state_q == ST_RUN) && match_now;
  assign miss_ev  = (state_q == ST_RUN) && !match_now && (chk_next == lim_q);
  assign finish   = hit_ev || miss_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pid_q      <= '0;
      vpn_q      <= '0;
      off_q      <= '0;
      lim_q      <= '0;
      idx_q      <= '0;
      pend_idx_q <= '0;
      pend_q     <= 1'b0;
      issued_q   <= '0;
      checked_q  <= '0;
      done_q     <= 1'b0;
      hit_q      <= 1'b0;
      paddr_q    <= '0;
      probes_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q   <= ST_RUN;
        pid_q     <= req_pid;
        vpn_q     <= req_vaddr[VADDR_W-1:OFF_W];
        off_q     <= req_vaddr[OFF_W-1:0];
        lim_q     <= probe_limit;
        idx_q     <= start_idx;
        issued_q  <= '0;
        checked_q <= '0;
        pend_q    <= 1'b0;
      end else if (state_q == ST_RUN) begin
        pend_q     <= issue && !finish;
        pend_idx_q <= idx_q;
        checked_q  <= chk_next;
        if (issue) begin
          idx_q    <= idx_q + 1'b1;
          issued_q <= issued_q + 1'b1;
        end
        if (finish) begin
          state_q  <= ST_IDLE;
          done_q   <= 1'b1;
          hit_q    <= hit_ev;
          probes_q <= chk_next;
          paddr_q  <= hit_ev ? {pend_idx_q, off_q} : '0;
        end
      end
    end
  end

  assign busy       = (state_q == ST_RUN);
  assign tbl_rd_en  = issue;
  assign tbl_rd_idx = idx_q;
  assign done       = done_q;
  assign hit        = hit_q;
  assign paddr      = paddr_q;
  assign probes     = probes_q;
endmodule

// File: rtl/ipt_search_chk.sv
module ipt_search_chk #(
  parameter int FRAME_W = 10,
  parameter int OFF_W   = 13,
  parameter int LIMIT_W = 11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     done,
  input logic                     hit,
  input logic [FRAME_W+OFF_W-1:0] paddr,
  input logic [LIMIT_W-1:0]       probes,
  input logic                     tbl_rd_en,
  input logic [FRAME_W-1:0]       tbl_rd_idx,
  input logic [LIMIT_W-1:0]       lim_q,
  input logic [OFF_W-1:0]         off_q
);
  logic [LIMIT_W:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_cnt <= '0;
    else if (done)      rd_cnt <= '0;
    else if (tbl_rd_en) rd_cnt <= rd_cnt + 1'b1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tbl_rd_en); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_PROBE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_en && $past(tbl_rd_en)) |-> (tbl_rd_idx == FRAME_W'($past(tbl_rd_idx) + 1'b1))); // R2
  AST_MISS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (probes == lim_q)); // R5
  AST_HIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (probes != '0 && probes <= lim_q && paddr[OFF_W-1:0] == off_q)); // R4
  AST_READ_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rd_cnt == {1'b0, probes}) || (hit && rd_cnt == {1'b0, probes} + 1'b1))); // R5
endmodule

bind ipt_search ipt_search_chk #(
  .FRAME_W(FRAME_W), .OFF_W(OFF_W), .LIMIT_W(LIMIT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .hit        (hit),
  .paddr      (paddr),
  .probes     (probes),
  .tbl_rd_en  (tbl_rd_en),
  .tbl_rd_idx (tbl_rd_idx),
  .lim_q      (lim_q),
  .off_q      (off_q)
);

// File: tb/ipt_search_bench.sv
`timescale 1ns/1ps
module ipt_search_bench;
  localparam int NF = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_pid = '0;
  logic [31:0] req_vaddr = '0;
  logic [10:0] probe_limit = '0;
  logic        busy, tbl_rd_en, done, hit;
  logic [9:0]  tbl_rd_idx;
  logic        tbl_ent_valid = 1'b0;
  logic [7:0]  tbl_ent_pid = '0;
  logic [18:0] tbl_ent_vpn = '0;
  logic [22:0] paddr;
  logic [10:0] probes;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  bit tv   [NF];
  int tpid [NF];
  int tvpn [NF];

  always #5 clk = ~clk;

  ipt_search u_ipt_search (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pid(req_pid),
    .req_vaddr(req_vaddr), .probe_limit(probe_limit), .busy(busy),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx), .tbl_ent_valid(tbl_ent_valid),
    .tbl_ent_pid(tbl_ent_pid), .tbl_ent_vpn(tbl_ent_vpn), .done(done),
    .hit(hit), .paddr(paddr), .probes(probes)
  );

  // Synchronous table model: data appears the cycle after the read strobe
  always @(posedge clk) begin
    if (tbl_rd_en) begin
      tbl_ent_valid <= tv[tbl_rd_idx];
      tbl_ent_pid   <= 8'(tpid[tbl_rd_idx]);
      tbl_ent_vpn   <= 19'(tvpn[tbl_rd_idx]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected<=200000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  function automatic int bhash(int pid, int vpn);
    return ((vpn % 1024) ^ (vpn / 1024) ^ pid) % 1024;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(int idx, bit v, int pid, int vpn);
    tv[idx % NF]   = v;
    tpid[idx % NF] = pid;
    tvpn[idx % NF] = vpn;
  endtask

  task automatic do_search(input int pid, input int vpn, input int off, input int lim,
                           input bit glitch);
    int  h, k, fr, d, exp_probes, exp_paddr;
    bit  exp_hit;
    h = bhash(pid, vpn);
    k = 0;
    fr = 0;
    for (int j = 0; j < lim; j++) begin
      int i;
      i = (h + j) % NF;
      if (tv[i] && tpid[i] == pid && tvpn[i] == vpn) begin
        k = j + 1;
        fr = i;
        break;
      end
    end
    exp_hit    = (k != 0);
    d          = exp_hit ? k + 1 : lim + 1;
    exp_probes = exp_hit ? k : lim;
    exp_paddr  = exp_hit ? (fr * 8192 + off) : 0;

    @(negedge clk);
    req_valid   = 1'b1;
    req_pid     = 8'(pid);
    req_vaddr   = 32'(vpn * 8192 + off);
    probe_limit = 11'(lim);
    @(posedge clk);
    @(negedge clk);
    if (glitch) begin
      // a second request while busy must be ignored (R7)
      req_pid     = 8'(pid + 1);
      req_vaddr   = 32'h0000_1234;
      probe_limit = 11'd0;
    end else begin
      req_valid = 1'b0;
    end
    for (int c = 0; c <= d + 1; c++) begin
      bit exp_rd;
      if (c == 1) req_valid = 1'b0;
      exp_rd = (c < lim) && (c < d);
      check(done == (c == d), "R6 done window", done, c == d);
      check(busy == (c < d), "R7 busy", busy, c < d);
      check(tbl_rd_en == exp_rd, "R2 read strobe", tbl_rd_en, exp_rd);
      if (exp_rd && tbl_rd_en)
        check(tbl_rd_idx == 10'((h + c) % NF), (c == 0) ? "R1 start index" : "R2 probe index",
              tbl_rd_idx, (h + c) % NF);
      if (c >= d) begin
        check(hit == exp_hit, exp_hit ? "R3 hit flag" : "R5 miss flag", hit, exp_hit);
        check(probes == 11'(exp_probes), exp_hit ? "R4 probes" : "R5 probes", probes, exp_probes);
        if (exp_hit)
          check(paddr == 23'(exp_paddr), (c == d) ? "R4 paddr" : "R7 paddr hold", paddr, exp_paddr);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < NF; i++) put(i, 1'b0, 0, 0);
    // key A: direct hit at the hashed index
    put(bhash(5, 'h12345), 1'b1, 5, 'h12345);
    // key B: three non-matching entries before the match (R3)
    put(bhash(3, 'h100) + 0, 1'b1, 4, 'h100);
    put(bhash(3, 'h100) + 1, 1'b0, 3, 'h100);
    put(bhash(3, 'h100) + 2, 1'b1, 3, 'h101);
    put(bhash(3, 'h100) + 3, 1'b1, 3, 'h100);
    // key C: hashes to 1022, match after wrapping to index 1
    put(1022, 1'b1, 1, 'h3FE);
    put(1023, 1'b0, 0, 'h3FE);
    put(0,    1'b1, 0, 'h3FF);
    put(1,    1'b1, 0, 'h3FE);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 0, "R8 busy", busy, 0);
    check(done == 0, "R8 done", done, 0);
    check(hit == 0, "R8 hit", hit, 0);
    check(tbl_rd_en == 0, "R8 rd_en", tbl_rd_en, 0);
    check(paddr == 0, "R8 paddr", paddr, 0);
    check(probes == 0, "R8 probes", probes, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_search(5, 'h12345, 'h0ABC, 16, 1'b0);   // R1 R4 hit on first probe
    do_search(3, 'h100,   'h1FFF, 8,  1'b1);   // R3 skips, R7 ignored request
    do_search(0, 'h3FE,   'h0001, 8,  1'b0);   // R2 wrap, hit at probe 4
    do_search(0, 'h3FE,   'h0002, 3,  1'b0);   // R5 limit one short of match
    do_search(0, 'h3FE,   'h0003, 4,  1'b0);   // R4 limit exactly reaches match
    do_search(5, 'h12345, 'h0000, 0,  1'b0);   // R5 zero limit, no reads
    do_search(7, 'h55555, 'h0777, 12, 1'b0);   // R5 unmapped key

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule